// File: doc/BRIEF.md
# Chained Vector Multiply-Add Pipeline

This block computes `d[n] = a[n] * (b[n] + c[n])` over a vector of 1 to 64 elements. It does not replicate the arithmetic per element. It reads one element index per clock and streams the operands through one shared adder pipeline and one shared multiplier pipeline. Integer arithmetic stands in for floating point. The adder has 6 register stages and the multiplier has 7, and these stage counts model the latency.

The two pipelines are chained. Each sum enters the multiplier on the same clock it leaves the adder, so the multiply does not wait for the whole add vector to finish. The `a` operand travels beside the sum through the adder stages, so it reaches the multiplier together with the matching sum. The complete expression for a vector of length L is therefore finished L + 13 cycles after the first element is read, not about 2L cycles.

A caller pulses `start_i` with a length. The block then drives an element index on its read port and takes `a`, `b` and `c` back combinationally in the same cycle. Each result appears on the write port with a strobe and its index. A one-cycle `done_o` pulse marks completion.

Top module: `vec_chain_pipe`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released, `rd_en_o`, `d_we_o`, `busy_o` and `done_o` are 0. A reset during a run discards every element still in flight, so no write follows it.
- R2: After a start is accepted at a clock edge, element indices 0, 1, …, L−1 are read one per cycle, in ascending order, from the next cycle on, with `rd_en_o` high exactly in those L cycles.
- R3: `d_data_o` equals the low 32 bits of `a * ((b + c) mod 2^32)`, where a, b and c are the operands read for the same index.
- R4: Counting the first read cycle as cycle 0, the write for element n appears in cycle n + 13. This is 6 adder stages followed directly by 7 multiplier stages.
- R5: Exactly L writes occur, in L consecutive cycles, with `d_idx_o` running from 0 to L−1.
- R6: `done_o` is high for exactly one cycle, the cycle after the last write (cycle L + 13).
- R7: A start with length 0 reads and writes nothing, and raises `done_o` in the cycle after the start edge.
- R8: A length above 64 (the 7-bit field allows up to 127) is processed as 64.
- R9: A start pulse that arrives while `busy_o` is high is ignored. This applies in both the read phase and the drain phase, and the running vector's reads and writes are unchanged.
- R10: `busy_o` is high from the cycle after an accepted non-zero start through the last write cycle, and is low in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled on the rising edge |
| len_i | input | 7 | Vector length, 0 to 127 (values above 64 are treated as 64) |
| rd_en_o | output | 1 | Element read strobe |
| rd_idx_o | output | 6 | Element index being read |
| a_i | input | 32 | Operand a for `rd_idx_o`, same cycle |
| b_i | input | 32 | Operand b for `rd_idx_o`, same cycle |
| c_i | input | 32 | Operand c for `rd_idx_o`, same cycle |
| d_we_o | output | 1 | Result write strobe |
| d_idx_o | output | 6 | Index of the result being written |
| d_data_o | output | 32 | Result value |
| busy_o | output | 1 | Vector in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 32-bit data, a maximum length of 64, and 6 adder plus 7 multiplier stages. With these values the 6-bit index runs its full range up to 63, and the clamp of the 7-bit length field can be exercised with a length of 100. The fixed 13-cycle chained latency can be checked cycle by cycle against lengths both shorter and longer than the pipeline depth. Wrap-around operands probe the modulo behaviour of both the adder and the multiplier.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int unsigned VC_DATA_W  = 32;
  localparam int unsigned VC_MAX_LEN = 64;
  localparam int unsigned VC_ADD_LAT = 6;
  localparam int unsigned VC_MUL_LAT = 7;
endpackage

// File: rtl/vc_delay_line.sv
module vc_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  if (DEPTH == 0) begin : g_thru
    assign vld_o  = vld_i;
    assign data_o = data_i;
  end else begin : g_pipe
    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     data_q [DEPTH];

    // only valid bits are reset; data follows its valid bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
      end else begin
        vld_q[0] <= vld_i;
        for (int s = 1; s < DEPTH; s++) vld_q[s] <= vld_q[s-1];
      end
    end

    always_ff @(posedge clk_i) begin
      data_q[0] <= data_i;
      for (int s = 1; s < DEPTH; s++) data_q[s] <= data_q[s-1];
    end

    assign vld_o  = vld_q[DEPTH-1];
    assign data_o = data_q[DEPTH-1];
  end
endmodule

// File: rtl/vc_issue_ctrl.sv
module vc_issue_ctrl #(
  parameter int unsigned MAX_LEN = vc_pkg::VC_MAX_LEN,
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wr_vld_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [LEN_W-1:0] eff_len;
  logic [IDX_W-1:0] cnt_q, last_q;
  logic             issue_q, busy_q, done_q;
  logic             wr_last;

  assign eff_len = (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
  assign wr_last = wr_vld_i && (wr_idx_i == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      last_q  <= '0;
      issue_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        if (len_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          issue_q <= 1'b1;
          cnt_q   <= '0;
          last_q  <= IDX_W'(eff_len - 1'b1);
        end
      end else begin
        if (issue_q) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == last_q) issue_q <= 1'b0;
        end
        // busy spans drain: released only by the last chained write
        if (busy_q && wr_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rd_en_o  = issue_q;
  assign rd_idx_o = cnt_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/vec_chain_pipe.sv
module vec_chain_pipe #(
  parameter int unsigned DATA_W  = vc_pkg::VC_DATA_W,
  parameter int unsigned MAX_LEN = vc_pkg::VC_MAX_LEN,
  parameter int unsigned ADD_LAT = vc_pkg::VC_ADD_LAT,
  parameter int unsigned MUL_LAT = vc_pkg::VC_MUL_LAT,
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned LEN_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic              d_we_o,
  output logic [IDX_W-1:0]  d_idx_o,
  output logic [DATA_W-1:0] d_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned ADD_W = IDX_W + 2 * DATA_W;
  localparam int unsigned MUL_W = IDX_W + DATA_W;

  logic [DATA_W-1:0] sum_in;
  logic              add_vld;
  logic [ADD_W-1:0]  add_out;
  logic [IDX_W-1:0]  add_idx;
  logic [DATA_W-1:0] add_a, add_sum, prod;

  vc_issue_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .len_i    (len_i),
    .wr_vld_i (d_we_o),
    .wr_idx_i (d_idx_o),
    .rd_en_o  (rd_en_o),
    .rd_idx_o (rd_idx_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign sum_in = b_i + c_i;

  // a rides in the adder payload so it meets its own sum at the multiplier
  vc_delay_line #(.W(ADD_W), .DEPTH(ADD_LAT)) u_add_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (rd_en_o),
    .data_i ({rd_idx_o, a_i, sum_in}),
    .vld_o  (add_vld),
    .data_o (add_out)
  );

  assign {add_idx, add_a, add_sum} = add_out;
  assign prod = add_a * add_sum;

  // chaining: adder output feeds the multiplier the same cycle
  vc_delay_line #(.W(MUL_W), .DEPTH(MUL_LAT)) u_mul_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (add_vld),
    .data_i ({add_idx, prod}),
    .vld_o  (d_we_o),
    .data_o ({d_idx_o, d_data_o})
  );
endmodule

// File: rtl/vec_chain_pipe_chk.sv
module vec_chain_pipe_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             d_we_o,
  input logic [IDX_W-1:0] d_idx_o,
  input logic             busy_o,
  input logic             done_o
);
  // R1 / R10: nothing moves outside a run
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_en_o && !d_we_o));

  a_r2_rd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));

  a_r2_rd_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> (rd_idx_o == '0));

  a_r5_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o && $past(d_we_o)) |-> (d_idx_o == IDX_W'($past(d_idx_o) + 1'b1)));

  a_r6_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> $past(d_we_o));

  a_r10_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind vec_chain_pipe vec_chain_pipe_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_en_o  (rd_en_o),
  .rd_idx_o (rd_idx_o),
  .d_we_o   (d_we_o),
  .d_idx_o  (d_idx_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/sim_vec_chain_pipe.sv
module sim_vec_chain_pipe;
  localparam int DW = 32;
  localparam int IW = 6;
  localparam int LW = 7;
  localparam int LAT = 13;
  localparam int NVEC = 6;
  localparam int VEC_LEN  [NVEC] = '{1, 2, 6, 13, 40, 64};
  localparam int VEC_SEED [NVEC] = '{3, 11, 5, 29, 77, 1};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start;
  logic [LW-1:0] len;
  logic          rd_en, d_we, busy, done;
  logic [IW-1:0] rd_idx, d_idx;
  logic [DW-1:0] a_rd, b_rd, c_rd, d_data;
  logic [DW-1:0] a_mem [64];
  logic [DW-1:0] b_mem [64];
  logic [DW-1:0] c_mem [64];

  assign a_rd = a_mem[rd_idx];
  assign b_rd = b_mem[rd_idx];
  assign c_rd = c_mem[rd_idx];

  vec_chain_pipe u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .rd_en_o(rd_en), .rd_idx_o(rd_idx), .a_i(a_rd), .b_i(b_rd), .c_i(c_rd),
    .d_we_o(d_we), .d_idx_o(d_idx), .d_data_o(d_data),
    .busy_o(busy), .done_o(done)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_d(input int n);
    logic [DW-1:0] s;
    s = b_mem[n] + c_mem[n];
    return a_mem[n] * s;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 64; i++) begin
      a_mem[i] = DW'(seed * 7 + i * 3 + 1);
      b_mem[i] = DW'(seed * 1000 + i * 17);
      c_mem[i] = DW'(i * i + seed);
    end
  endtask

  // one vector; poke >= 0 drives a stray start in that cycle
  task automatic run_vec(input int l, input int poke, input string tag);
    int eff = (l > 64) ? 64 : l;
    int e_rd = 0, e_wr = 0, e_dat = 0, e_done = 0, e_busy = 0;
    bit exp_rd, exp_we;
    @(negedge clk); start = 1'b1; len = LW'(l);
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < eff + LAT + 3; k++) begin
      exp_rd = (k < eff);
      if (rd_en !== exp_rd || (exp_rd && rd_idx !== IW'(k))) e_rd++;
      exp_we = (k >= LAT) && (k < eff + LAT);
      if (d_we !== exp_we) e_wr++;
      else if (exp_we && (d_idx !== IW'(k - LAT) || d_data !== exp_d(k - LAT))) e_dat++;
      if (done !== (k == eff + LAT)) e_done++;
      if (busy !== (k < eff + LAT)) e_busy++;
      start = (k == poke);
      if (k == poke) len = LW'(5);
      @(negedge clk);
    end
    start = 1'b0;
    chk(e_rd == 0,   "R2", {tag, " read sequence mismatches"}, e_rd, 0);
    chk(e_wr == 0,   "R4", {tag, " write timing mismatches"}, e_wr, 0);
    chk(e_dat == 0,  "R3", {tag, " data/index (R5) mismatches"}, e_dat, 0);
    chk(e_done == 0, "R6", {tag, " done pulse mismatches"}, e_done, 0);
    chk(e_busy == 0, "R10", {tag, " busy mismatches"}, e_busy, 0);
    if (poke >= 0) chk(e_rd + e_wr + e_dat == 0, "R9", {tag, " stray start disturbed run"}, e_rd + e_wr + e_dat, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; start = 1'b0; len = '0;
    fill(0);
    repeat (3) @(negedge clk);
    chk({rd_en, d_we, busy, done} === 4'b0, "R1", "outputs in reset", {rd_en, d_we, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rd_en, d_we, busy, done} === 4'b0, "R1", "outputs after release", {rd_en, d_we, busy, done}, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      fill(VEC_SEED[v]);
      run_vec(VEC_LEN[v], -1, $sformatf("len %0d", VEC_LEN[v]));
    end

    // R8: over-length clamps to 64
    fill(9);
    run_vec(100, -1, "R8 len 100");

    // R3: modulo wrap in both adder and multiplier
    for (int i = 0; i < 64; i++) begin
      a_mem[i] = 32'h8000_0001 + DW'(i);
      b_mem[i] = 32'hFFFF_FFF0 + DW'(i);
      c_mem[i] = 32'h0000_0020;
    end
    run_vec(8, -1, "R3 wrap");

    // R9: stray starts in read phase and in drain phase
    fill(42);
    run_vec(10, 3, "R9 read phase");
    run_vec(20, 25, "R9 drain phase");

    // R7: zero length
    @(negedge clk); start = 1'b1; len = '0;
    @(negedge clk); start = 1'b0;
    chk(done === 1'b1, "R7", "done after zero-length start", done, 1);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (rd_en || d_we || busy) cnt++;
      @(negedge clk);
      if (done) cnt++;
    end
    chk(cnt == 0, "R7", "activity after zero-length start", cnt, 0);

    // R1: reset mid-run flushes the pipelines
    fill(5);
    @(negedge clk); start = 1'b1; len = LW'(30);
    @(negedge clk); start = 1'b0;
    repeat (16) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({rd_en, d_we, busy, done} === 4'b0, "R1", "outputs in mid-run reset", {rd_en, d_we, busy, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      if (rd_en || d_we || busy || done) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R1", "activity after mid-run reset", cnt, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule